// File: doc/BRIEF.md
# Drive Identify Table and Geometry Loader

This block keeps the 256-word identification table that an ATA-style disk controller returns to a host. It also keeps the set of media geometry values that the controller's neighbours read. Both are filled from a write-only management port. A 3-bit management address picks the target. Address 0 is a stream port: each 32-bit write there deposits two consecutive 16-bit table words at an internal pair pointer, and that pointer then advances. The other addresses each load one geometry register.

When the controller answers an identification command, it pulses a start input. It then pulls the table out one 16-bit word per read strobe. A done flag goes high once the last word has been consumed. The geometry registers feed the controller's command and addressing logic directly, as plain outputs.

Top module: `idl_loader`

## Requirements
- R1: After reset the pair pointer and the read index are zero, the done flag is low and every geometry output is zero.
- R2: A write to management address 0 stores data bits 15:0 as table word 2k and bits 31:16 as word 2k+1, where k is the pair pointer.
- R3: Each address-0 write advances the pair pointer by one. After pair 127 it wraps to 0, so the 129th write overwrites words 0 and 1.
- R4: Address 1 loads the cylinder count from bits 16:0, address 2 the head count from bits 4:0, address 3 sectors per track from bits 8:0, and address 4 sectors per cylinder from bits 13:0. Higher data bits are dropped.
- R5: Address 5 loads the 32-bit total sector count, and address 6 loads the 32-bit base sector on the backing store.
- R6: A write to address 7, or any cycle with the write enable low, changes no geometry output and leaves the pair pointer where it was.
- R7: The readout output shows the table word at the read index. Each read strobe advances the index by one on the next clock.
- R8: The start input returns the read index to word 0 and clears done. It wins over a read strobe in the same cycle.
- R9: Done rises on the clock that consumes word 255. While done is high, read strobes leave the output on word 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mgmt_addr_i | input | 3 | Management register select |
| mgmt_we_i | input | 1 | Management write enable |
| mgmt_wdata_i | input | 32 | Management write data |
| id_start_i | input | 1 | Begin a new table readout |
| id_rd_i | input | 1 | Consume one table word |
| id_data_o | output | 16 | Table word at the read index |
| id_done_o | output | 1 | All table words consumed |
| cyl_o | output | 17 | Cylinder count |
| heads_o | output | 5 | Head count |
| spt_o | output | 9 | Sectors per track |
| spc_o | output | 12+2 | Sectors per cylinder (14 bits) |
| total_o | output | 32 | Total sector count |
| base_o | output | 32 | Base sector on backing store |

## Verification
The table is filled with a hashed word pattern in which every word differs from its neighbours. This makes a swapped half-word, an off-by-one pointer or a missed increment show up as a wrong value at a known index. Geometry writes use all-ones and upper-garbage data, which separates correct field truncation from a shifted or widened field. A final write to the unused address checks that nothing moves. After the full pass, a 129th stream write and a stream write following an address-7 write are read back at words 0 to 3. These tell wrapping and ignored writes apart from a pointer that drifts. Strobes after done, and a start in the same cycle as a read, probe the readout edge cases.

// File: rtl/idl_pkg.sv
package idl_pkg;
  typedef enum logic [2:0] {
    MA_IDENT = 3'd0,
    MA_CYL   = 3'd1,
    MA_HEADS = 3'd2,
    MA_SPT   = 3'd3,
    MA_SPC   = 3'd4,
    MA_TOTAL = 3'd5,
    MA_BASE  = 3'd6,
    MA_NONE  = 3'd7
  } mgmt_addr_e;
endpackage

// File: rtl/idl_table.sv
module idl_table #(
  parameter int WORDS  = 256,
  parameter int WORD_W = 16,
  localparam int RD_W  = $clog2(WORDS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [2*WORD_W-1:0]   wr_data_i,
  input  logic [RD_W-1:0]       rd_idx_i,
  output logic [WORD_W-1:0]     rd_word_o
);
  localparam int PAIRS = WORDS / 2;
  localparam int WP_W  = RD_W - 1;
  localparam logic [WP_W-1:0] LAST_PAIR = WP_W'(PAIRS - 1);

  logic [WORD_W-1:0] mem_q [WORDS];
  logic [WP_W-1:0]   wptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wptr_q <= '0;
    else if (wr_en_i) wptr_q <= (wptr_q == LAST_PAIR) ? '0 : wptr_q + 1'b1;
  end

  // even word from low half, odd word from high half
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      mem_q[{wptr_q, 1'b0}] <= wr_data_i[WORD_W-1:0];
      mem_q[{wptr_q, 1'b1}] <= wr_data_i[2*WORD_W-1:WORD_W];
    end
  end

  assign rd_word_o = mem_q[rd_idx_i];

  assert_wptr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(wptr_q));
  assert_wptr_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wptr_q == LAST_PAIR) |=> (wptr_q == '0));
  assert_wptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wptr_q != LAST_PAIR) |=> (wptr_q == $past(wptr_q) + 1'b1));
endmodule

// File: rtl/idl_geom.sv
module idl_geom
  import idl_pkg::*;
#(
  parameter int CYL_W  = 17,
  parameter int HEAD_W = 5,
  parameter int SPT_W  = 9,
  parameter int SPC_W  = 14,
  parameter int CNT_W  = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  mgmt_addr_e       addr_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CYL_W-1:0]  cyl_o,
  output logic [HEAD_W-1:0] heads_o,
  output logic [SPT_W-1:0]  spt_o,
  output logic [SPC_W-1:0]  spc_o,
  output logic [CNT_W-1:0]  total_o,
  output logic [CNT_W-1:0]  base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyl_o   <= '0;
      heads_o <= '0;
      spt_o   <= '0;
      spc_o   <= '0;
      total_o <= '0;
      base_o  <= '0;
    end else if (we_i) begin
      case (addr_i)
        MA_CYL:   cyl_o   <= data_i[CYL_W-1:0];
        MA_HEADS: heads_o <= data_i[HEAD_W-1:0];
        MA_SPT:   spt_o   <= data_i[SPT_W-1:0];
        MA_SPC:   spc_o   <= data_i[SPC_W-1:0];
        MA_TOTAL: total_o <= data_i;
        MA_BASE:  base_o  <= data_i;
        default:  ;
      endcase
    end
  end

  assert_cyl_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == MA_CYL) |=> $stable(cyl_o));
  assert_heads_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == MA_HEADS) |=> $stable(heads_o));
  assert_total_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == MA_TOTAL) |=> (total_o == $past(data_i)));
  assert_base_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == MA_BASE) |=> $stable(base_o));
endmodule

// File: rtl/idl_reader.sv
module idl_reader #(
  parameter int WORDS = 256,
  localparam int RD_W = $clog2(WORDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            rd_i,
  output logic [RD_W-1:0] idx_o,
  output logic            done_o
);
  localparam logic [RD_W-1:0] LAST = RD_W'(WORDS - 1);

  logic [RD_W-1:0] idx_q;
  logic            done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      idx_q  <= '0;
      done_q <= 1'b0;
    end else if (rd_i && !done_q) begin
      if (idx_q == LAST) done_q <= 1'b1;  // index parks on last word
      else               idx_q  <= idx_q + 1'b1;
    end
  end

  assign idx_o  = idx_q;
  assign done_o = done_q;

  assert_start_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (idx_q == '0 && !done_q));
  assert_done_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(rd_i && idx_q == LAST));
  assert_done_park_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !start_i) |=> $stable(idx_q));
  assert_idx_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !start_i && !done_q && idx_q != LAST) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/idl_loader.sv
module idl_loader
  import idl_pkg::*;
#(
  parameter int WORDS  = 256,
  parameter int WORD_W = 16,
  parameter int CYL_W  = 17,
  parameter int HEAD_W = 5,
  parameter int SPT_W  = 9,
  parameter int SPC_W  = 14,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        mgmt_addr_i,
  input  logic              mgmt_we_i,
  input  logic [CNT_W-1:0]  mgmt_wdata_i,
  input  logic              id_start_i,
  input  logic              id_rd_i,
  output logic [WORD_W-1:0] id_data_o,
  output logic              id_done_o,
  output logic [CYL_W-1:0]  cyl_o,
  output logic [HEAD_W-1:0] heads_o,
  output logic [SPT_W-1:0]  spt_o,
  output logic [SPC_W-1:0]  spc_o,
  output logic [CNT_W-1:0]  total_o,
  output logic [CNT_W-1:0]  base_o
);
  localparam int RD_W = $clog2(WORDS);

  mgmt_addr_e      addr;
  logic            ident_we;
  logic [RD_W-1:0] rd_idx;

  assign addr     = mgmt_addr_e'(mgmt_addr_i);
  assign ident_we = mgmt_we_i && (addr == MA_IDENT);

  idl_table #(.WORDS(WORDS), .WORD_W(WORD_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (ident_we),
    .wr_data_i (mgmt_wdata_i[2*WORD_W-1:0]),
    .rd_idx_i  (rd_idx),
    .rd_word_o (id_data_o)
  );

  idl_reader #(.WORDS(WORDS)) u_reader (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (id_start_i),
    .rd_i    (id_rd_i),
    .idx_o   (rd_idx),
    .done_o  (id_done_o)
  );

  idl_geom #(
    .CYL_W(CYL_W), .HEAD_W(HEAD_W), .SPT_W(SPT_W), .SPC_W(SPC_W), .CNT_W(CNT_W)
  ) u_geom (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mgmt_we_i),
    .addr_i  (addr),
    .data_i  (mgmt_wdata_i),
    .cyl_o   (cyl_o),
    .heads_o (heads_o),
    .spt_o   (spt_o),
    .spc_o   (spc_o),
    .total_o (total_o),
    .base_o  (base_o)
  );
endmodule

// File: tb/idl_loader_tb.sv
`timescale 1ns/1ps
module idl_loader_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  mgmt_addr_i = '0;
  logic        mgmt_we_i = 1'b0;
  logic [31:0] mgmt_wdata_i = '0;
  logic        id_start_i = 1'b0;
  logic        id_rd_i = 1'b0;
  logic [15:0] id_data_o;
  logic        id_done_o;
  logic [16:0] cyl_o;
  logic [4:0]  heads_o;
  logic [8:0]  spt_o;
  logic [13:0] spc_o;
  logic [31:0] total_o, base_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  idl_loader u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mgmt_addr_i(mgmt_addr_i), .mgmt_we_i(mgmt_we_i),
    .mgmt_wdata_i(mgmt_wdata_i), .id_start_i(id_start_i), .id_rd_i(id_rd_i),
    .id_data_o(id_data_o), .id_done_o(id_done_o), .cyl_o(cyl_o), .heads_o(heads_o),
    .spt_o(spt_o), .spc_o(spc_o), .total_o(total_o), .base_o(base_o)
  );

  localparam int NV = 8;
  localparam logic [2:0]  VA [NV] = '{3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd1, 3'd7};
  localparam logic [31:0] VD [NV] = '{32'hFFFF_FFFF, 32'hFFFF_FFE3, 32'h0000_003F, 32'h1234_3EF0,
                                      32'h000F_C000, 32'hA5A5_0001, 32'h0000_0400, 32'hDEAD_BEEF};
  localparam logic [31:0] VE [NV] = '{32'h0001_FFFF, 32'h0000_0003, 32'h0000_003F, 32'h0000_3EF0,
                                      32'h000F_C000, 32'hA5A5_0001, 32'h0000_0400, 32'h0000_0400};

  function automatic logic [15:0] idw(int i);
    return 16'((i * 40503) ^ 23130);
  endfunction

  // address 7 has no register: observe cylinder output instead
  function automatic logic [31:0] geom_sel(logic [2:0] a);
    case (a)
      3'd2: return 32'(heads_o);
      3'd3: return 32'(spt_o);
      3'd4: return 32'(spc_o);
      3'd5: return total_o;
      3'd6: return base_o;
      default: return 32'(cyl_o);
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic mwr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    mgmt_addr_i = a; mgmt_wdata_i = d; mgmt_we_i = 1'b1;
    @(negedge clk);
    mgmt_we_i = 1'b0;
  endtask

  task automatic pulse_rd();
    id_rd_i = 1'b1;
    @(negedge clk);
    id_rd_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    id_start_i = 1'b1;
    @(negedge clk);
    id_start_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", 32'(id_done_o), 0);
    chk("R1 cyl", 32'(cyl_o), 0);
    chk("R1 heads", 32'(heads_o), 0);
    chk("R1 spt", 32'(spt_o), 0);
    chk("R1 spc", 32'(spc_o), 0);
    chk("R1 total", total_o, 0);
    chk("R1 base", base_o, 0);

    // R4 R5 R6 geometry vectors
    for (int v = 0; v < NV; v++) begin
      mwr(VA[v], VD[v]);
      chk($sformatf("R4/R5/R6 vec%0d", v), geom_sel(VA[v]), VE[v]);
    end
    chk("R6 heads after addr7", 32'(heads_o), 32'h3);
    chk("R6 total after addr7", total_o, 32'h000F_C000);
    @(negedge clk);
    mgmt_addr_i = 3'd2; mgmt_wdata_i = 32'h1F; mgmt_we_i = 1'b0;
    @(negedge clk);
    chk("R6 heads with we low", 32'(heads_o), 32'h3);

    // R2 fill table
    for (int k = 0; k < 128; k++) mwr(3'd0, {idw(2*k+1), idw(2*k)});
    chk("R6 geom kept by stream", 32'(cyl_o), 32'h400);

    // R7 R9 full readout; R1 read index starts at 0
    pulse_start();
    for (int i = 0; i < 256; i++) begin
      chk($sformatf("R2/R7 word%0d", i), 32'(id_data_o), 32'(idw(i)));
      if (i == 255) chk("R9 done before last", 32'(id_done_o), 0);
      pulse_rd();
    end
    chk("R9 done after last", 32'(id_done_o), 1);
    pulse_rd();
    chk("R9 parked data", 32'(id_data_o), 32'(idw(255)));
    chk("R9 done held", 32'(id_done_o), 1);

    // R3 wrap, R6 addr7 does not move pointer
    mwr(3'd0, 32'hBEEF_CAFE);
    mwr(3'd7, 32'h5555_5555);
    mwr(3'd0, 32'h2222_1111);
    pulse_start();
    chk("R8 done cleared", 32'(id_done_o), 0);
    chk("R3 word0", 32'(id_data_o), 32'hCAFE);
    pulse_rd();
    chk("R3 word1", 32'(id_data_o), 32'hBEEF);
    pulse_rd();
    chk("R6 word2", 32'(id_data_o), 32'h1111);
    pulse_rd();
    chk("R6 word3", 32'(id_data_o), 32'h2222);
    pulse_rd();
    chk("R3 word4 kept", 32'(id_data_o), 32'(idw(4)));

    // R8 start beats read in same cycle
    id_start_i = 1'b1; id_rd_i = 1'b1;
    @(negedge clk);
    id_start_i = 1'b0; id_rd_i = 1'b0;
    chk("R8 start priority", 32'(id_data_o), 32'hCAFE);
    chk("R8 done low", 32'(id_done_o), 0);
    @(negedge clk);
    chk("R7 idle hold", 32'(id_data_o), 32'hCAFE);

    finish_run();
  end
endmodule